// File: doc/BRIEF.md
# DMA Bridge Event Interrupt Controller

This block holds one 32-bit control and status word for a DMA bridge that moves data between USB and audio peripherals and main memory. Ten event sources arrive as single-cycle pulses: a USB transfer completion, a USB address fault, and, for each of two audio channels, a full-buffer and a half-buffer event in both the playback and capture directions. Each pulse sets a sticky pending bit. Each pending bit has its own enable bit.

The enabled pending bits are merged onto three registered, level-sensitive interrupt lines. The USB fault has a line to itself. The USB completion shares a line with the four audio full-buffer events. The four audio half-buffer events share the third line. Software reads the word to see which events are pending and acknowledges an event by writing 0 to its pending bit. Writing 0 to an enable bit masks the event from every line.

There is no state machine. Each event has one pending/enable pair, and each line has one output register. The only sequencing is a single register stage between pending bits and lines.

Top module: `dbirq_ctrl`

## Requirements
- R1: Reset clears all 32 bits of `rd_data` and all three `irq_o` lines.
- R2: A pulse on `evt_i[n]` sets its pending bit at the next clock edge, whether or not the event is enabled. The pending bit of event 0 is bit 0 and that of event 1 is bit 1. Events 2 to 9 use bits n+14, which is 16 to 23.
- R3: A write with `wr_data` bit 0 at a pending position clears that bit. A 1 at a pending position leaves the bit unchanged.
- R4: If an event pulse arrives in the same cycle as a write that clears its pending bit, the bit stays set.
- R5: Enable bits take the written value on every write and keep their value otherwise. The enable of event 0 is bit 8 and that of event 1 is bit 9. Events 2 to 9 use bits n+22, which is 24 to 31.
- R6: Line `irq_o[0]` is high exactly when event 1 (USB fault) was pending and enabled one cycle earlier.
- R7: Line `irq_o[1]` is high exactly when at least one of events 0, 2, 4, 6 or 8 was pending and enabled one cycle earlier. Events 2 and 6 are playback full-buffer on audio channels 0 and 1. Events 4 and 8 are capture full-buffer on those channels.
- R8: Line `irq_o[2]` is high exactly when at least one of events 3, 5, 7 or 9 (the half-buffer events) was pending and enabled one cycle earlier.
- R9: Each line follows its pending and enable bits with exactly one cycle of delay, both when it rises and when it falls.
- R10: Bits 2 to 7 and 10 to 15 always read 0, whatever is written.
- R11: A pending event whose enable bit is 0 drives no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data: enable values and pending-clear mask |
| rd_data | output | 32 | Current register contents |
| evt_i | input | 10 | Event pulses, one bit per source |
| irq_o | output | 3 | Interrupt lines: 0 USB fault, 1 completion group, 2 half-buffer group |

## Verification
A corrupted pending or enable bit shows on `rd_data` in the cycle right after the faulty edge. It reaches the matching `irq_o` line one cycle later. A wrong line grouping or a wrong enable pairing therefore appears at the ports within two cycles of a single event pulse. The bench pulses each event with its enable both set and clear. It then runs a long pseudo-random mix of pulses and writes against an arithmetic model, so that a misplaced bit or a lost event fails within a few cycles.

// File: rtl/dbirq_pkg.sv
package dbirq_pkg;
    localparam int REG_W     = 32;
    localparam int NUM_EVT   = 10;
    localparam int NUM_LINES = 3;

    // pending-bit position for event n
    function automatic int stat_pos(input int n);
        return (n < 2) ? n : n + 14;
    endfunction

    // enable-bit position for event n
    function automatic int en_pos(input int n);
        return (n < 2) ? n + 8 : n + 22;
    endfunction

    // line that event n drives: 0 fault, 1 completion group, 2 half group
    function automatic int line_of(input int n);
        if (n == 1) return 0;
        if ((n % 2) == 0) return 1;
        return 2;
    endfunction
endpackage

// File: rtl/dbirq_flag_cell.sv
module dbirq_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_stat,
    input  logic wr_ena,
    input  logic evt,
    output logic stat_q,
    output logic ena_q,
    output logic req
);
    logic stat_d;
    logic ena_d;

    always_comb begin
        stat_d = stat_q;
        ena_d  = ena_q;
        if (wr_en) begin
            stat_d = stat_q & wr_stat;
            ena_d  = wr_ena;
        end
        stat_d = stat_d | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= 1'b0;
            ena_q  <= 1'b0;
        end else begin
            stat_q <= stat_d;
            ena_q  <= ena_d;
        end
    end

    assign req = stat_q & ena_q;
endmodule

// File: rtl/dbirq_line_merge.sv
module dbirq_line_merge
    import dbirq_pkg::*;
#(
    parameter int N_EVT   = NUM_EVT,
    parameter int N_LINES = NUM_LINES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_EVT-1:0]   req,
    output logic [N_LINES-1:0] irq_q
);
    function automatic logic [N_EVT-1:0] line_mask(input int l);
        logic [N_EVT-1:0] m;
        m = '0;
        for (int n = 0; n < N_EVT; n++) begin
            if (line_of(n) == l) m[n] = 1'b1;
        end
        return m;
    endfunction

    logic [N_LINES-1:0] line_d;

    for (genvar l = 0; l < N_LINES; l++) begin : g_line
        localparam logic [N_EVT-1:0] MASK = line_mask(l);
        assign line_d[l] = |(req & MASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= line_d;
    end
endmodule

// File: rtl/dbirq_ctrl.sv
module dbirq_ctrl
    import dbirq_pkg::*;
#(
    parameter int DATA_W  = REG_W,
    parameter int N_EVT   = NUM_EVT,
    parameter int N_LINES = NUM_LINES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]  rd_data,
    input  logic [N_EVT-1:0]   evt_i,
    output logic [N_LINES-1:0] irq_o
);
    function automatic logic [DATA_W-1:0] used_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int n = 0; n < N_EVT; n++) begin
            m[stat_pos(n)] = 1'b1;
            m[en_pos(n)]   = 1'b1;
        end
        return m;
    endfunction

    localparam logic [DATA_W-1:0] USED = used_mask();

    logic [N_EVT-1:0] stat_q;
    logic [N_EVT-1:0] ena_q;
    logic [N_EVT-1:0] req;
    logic             unused_wr;

    assign unused_wr = ^(wr_data & ~USED);

    for (genvar n = 0; n < N_EVT; n++) begin : g_evt
        localparam int SP = stat_pos(n);
        localparam int EP = en_pos(n);

        dbirq_flag_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .wr_stat (wr_data[SP]),
            .wr_ena  (wr_data[EP]),
            .evt     (evt_i[n]),
            .stat_q  (stat_q[n]),
            .ena_q   (ena_q[n]),
            .req     (req[n])
        );

        // R2: a pulse is latched at the next edge
        assert_evt_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[n] |=> rd_data[SP]);

        // R4: a clear never beats a simultaneous event
        assert_evt_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wr_data[SP] && evt_i[n]) |=> rd_data[SP]);

        // R3: a write-0 with no event clears
        assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wr_data[SP] && !evt_i[n]) |=> !rd_data[SP]);

        // R5: enable follows the written value
        assert_ena_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |=> (rd_data[EP] == $past(wr_data[EP])));
    end

    always_comb begin
        rd_data = '0;
        for (int n = 0; n < N_EVT; n++) begin
            rd_data[stat_pos(n)] = stat_q[n];
            rd_data[en_pos(n)]   = ena_q[n];
        end
    end

    dbirq_line_merge #(
        .N_EVT   (N_EVT),
        .N_LINES (N_LINES)
    ) u_merge (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .irq_q (irq_o)
    );

    // R10: reserved bits read as zero
    assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~USED) == '0);

    // R6: fault line follows bits 1 and 9 one cycle later
    assert_line0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[0] == $past(rd_data[1] & rd_data[9]));

    // R7: completion line
    assert_line1_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[1] == $past((rd_data[0] & rd_data[8]) | (rd_data[16] & rd_data[24]) |
                          (rd_data[18] & rd_data[26]) | (rd_data[20] & rd_data[28]) |
                          (rd_data[22] & rd_data[30])));

    // R8: half-buffer line
    assert_line2_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[2] == $past((rd_data[17] & rd_data[25]) | (rd_data[19] & rd_data[27]) |
                          (rd_data[21] & rd_data[29]) | (rd_data[23] & rd_data[31])));
endmodule

// File: tb/dbirq_ctrl_tb.sv
module dbirq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [9:0]  evt_i = '0;
    logic [2:0]  irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [31:0] reg_m = '0;
    logic [2:0]  irq_m = '0;
    logic [31:0] lfsr  = 32'hACE1_2468;

    always #2 clk = ~clk;

    dbirq_ctrl dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .evt_i   (evt_i),
        .irq_o   (irq_o)
    );

    function automatic int sp(input int n);
        return (n < 2) ? n : n + 14;
    endfunction
    function automatic int ep(input int n);
        return (n < 2) ? n + 8 : n + 22;
    endfunction

    function automatic logic [2:0] lines_of(input logic [31:0] r);
        logic [2:0] l;
        l = '0;
        for (int n = 0; n < 10; n++) begin
            if (r[sp(n)] && r[ep(n)]) begin
                if (n == 1)          l[0] = 1'b1;
                else if (n % 2 == 0) l[1] = 1'b1;
                else                 l[2] = 1'b1;
            end
        end
        return l;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one clock with given stimulus; called at a negedge, returns at the next negedge
    task automatic cyc(input logic we, input logic [31:0] wd, input logic [9:0] ev, input string tag);
        logic [31:0] nxt;
        wr_en   = we;
        wr_data = wd;
        evt_i   = ev;
        @(posedge clk);
        nxt = reg_m;
        for (int n = 0; n < 10; n++) begin
            if (we) begin
                nxt[sp(n)] = reg_m[sp(n)] & wd[sp(n)];
                nxt[ep(n)] = wd[ep(n)];
            end
            nxt[sp(n)] = nxt[sp(n)] | ev[n];
        end
        irq_m = lines_of(reg_m);
        reg_m = nxt;
        @(negedge clk);
        wr_en = 1'b0;
        evt_i = '0;
        check({tag, " reg"}, rd_data, reg_m);
        check({tag, " irq"}, {29'd0, irq_o}, {29'd0, irq_m});
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset reg", rd_data, 32'h0);
        check("R1 reset irq", {29'd0, irq_o}, 32'h0);

        // each event with its enable off and on
        for (int n = 0; n < 10; n++) begin
            for (int en = 0; en < 2; en++) begin
                logic [31:0] ew;
                ew = '0;
                ew[ep(n)] = en[0];
                cyc(1'b1, ew, '0, "R5 set enable");
                cyc(1'b0, '0, 10'(1) << n, "R2 latch");
                check("R2 bit position", {31'd0, rd_data[sp(n)]}, 32'd1);
                cyc(1'b0, '0, '0, "R6 R7 R8 R11 line");
                if (en == 0) check("R11 masked", {29'd0, irq_o}, 32'd0);
                else if (n == 1) check("R6 fault line", {29'd0, irq_o}, 32'd1);
                else if (n % 2 == 0) check("R7 done line", {29'd0, irq_o}, 32'd2);
                else check("R8 half line", {29'd0, irq_o}, 32'd4);
                cyc(1'b1, ew, '0, "R3 clear");
                check("R3 cleared", {31'd0, rd_data[sp(n)]}, 32'd0);
                cyc(1'b0, '0, '0, "R9 fall");
                check("R9 line low", {29'd0, irq_o}, 32'd0);
            end
        end

        // write 1 keeps, reserved bits stay 0
        cyc(1'b0, '0, 10'h3FF, "R2 all");
        cyc(1'b1, 32'hFFFF_FFFF, '0, "R3 keep");
        check("R10 reserved", rd_data & 32'h0000_FCFC, 32'h0);
        check("R3 keep all", rd_data, 32'hFFFF_0303);
        cyc(1'b0, '0, '0, "R9 all lines");
        check("R9 all high", {29'd0, irq_o}, 32'd7);
        // clear collides with event
        cyc(1'b1, 32'hFF00_0300, 10'h021, "R4 collide");
        check("R4 kept", rd_data, 32'hFF08_0301);

        // pseudo-random sweep
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a;
            logic [31:0] b;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            a = lfsr;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            b = lfsr;
            cyc(a[31:30] == 2'b00, b, a[9:0] & a[19:10] & a[29:20], "R2 R3 R4 R5 R10 sweep");
        end

        rst_n = 1'b0;
        reg_m = '0;
        @(negedge clk);
        check("R1 reset again", rd_data, 32'h0);
        check("R1 irq again", {29'd0, irq_o}, 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule